// File: doc/BRIEF.md
# Link Alignment Preamble Generator

This block sits in the user-logic side of a Gigabit Ethernet transmit lane, just ahead of the 8b/10b encoder. The transceiver has no hardware that sends an alignment preamble after power-up or after a transmit digital reset, so this block does that job. Each time its reset is released, it drives a fixed train of comma/data groups onto the byte lane. The far-end receiver uses this train to find its word boundary. After the last group, the block hands the lane to the user stream.

Each group is one K28.5 comma: the byte 8'hBC with the control-enable flag high. It is followed by an odd number of copies of a single data character, sent with control-enable low. The number of groups, the number of data characters per group and the data byte are all parameters. The defaults are three groups of one D0.0 (8'h00) each. The preamble and the user traffic both leave through the same output register.

Top module: `lnk_sync_gen`

## Requirements
- R1: On the first rising edge with `rst_i` low, the output register loads the comma: `enc_data_o` = 8'hBC and `enc_ctl_o` = 1 from the next cycle on.
- R2: The preamble consists of GROUPS groups on consecutive cycles. Each group is one comma (8'hBC, ctl 1) followed by FILLS fill characters (ctl 0). The default is 3 groups of 1 fill.
- R3: Each fill character equals the FILL_BYTE parameter, whose default is 8'h00. FILLS must be odd, and an even value stops elaboration.
- R4: While the preamble runs, `usr_data_i` and `usr_ctl_i` have no effect on the outputs, even when they carry 8'hBC with ctl 1.
- R5: `sync_done_o` is 0 during reset and during the preamble. It rises in the cycle after the last fill character is on the output, and it stays high until the next reset.
- R6: While `sync_done_o` is 1, the outputs equal the `usr_data_i`/`usr_ctl_i` values sampled on the previous rising edge (one register of latency).
- R7: Asserting `rst_i` part-way through the preamble abandons it. Releasing reset then starts a complete preamble again from the first comma.
- R8: While `rst_i` is sampled high, the outputs become data 8'h00, ctl 0 and done 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Lane clock |
| rst_i | input | 1 | Synchronous active-high reset (power-up or transmit digital reset) |
| usr_data_i | input | 8 | User byte |
| usr_ctl_i | input | 1 | User control-character flag |
| enc_data_o | output | 8 | Byte toward the encoder |
| enc_ctl_o | output | 1 | Control-enable toward the encoder |
| sync_done_o | output | 1 | Preamble finished; lane carries user traffic |

## Verification
The hardest case to reach from the ports is a reset that lands inside the preamble while the user side is offering comma look-alikes. In that case a restart bug could either resume at the old position or leak user bytes onto the lane. The stimulus drives 8'hBC with ctl high on every cycle of the preamble. It then pulses reset after the third character and checks the complete train again after release. A second instance, with three fills of 8'h4A per group, shows that the group and fill counts really come from the parameters.

// File: rtl/lnk_sync_pkg.sv
package lnk_sync_pkg;

  localparam logic [7:0] COMMA_K285 = 8'hBC;

  typedef struct packed {
    logic       ctl;
    logic [7:0] dat;
  } lane_t;

  // number of preamble characters
  function automatic int unsigned pre_len(int unsigned groups, int unsigned fills);
    return groups * (fills + 1);
  endfunction

  // character at preamble position idx
  function automatic lane_t pre_char(int unsigned idx, int unsigned fills,
                                     logic [7:0] fill_byte);
    lane_t c;
    if ((idx % (fills + 1)) == 0) begin
      c.ctl = 1'b1;
      c.dat = COMMA_K285;
    end else begin
      c.ctl = 1'b0;
      c.dat = fill_byte;
    end
    return c;
  endfunction

endpackage

// File: rtl/lnk_sync_seq.sv
module lnk_sync_seq
  import lnk_sync_pkg::*;
#(
  parameter int unsigned GROUPS    = 3,
  parameter int unsigned FILLS     = 1,
  parameter logic [7:0]  FILL_BYTE = 8'h00,
  localparam int unsigned LEN      = pre_len(GROUPS, FILLS),
  localparam int unsigned IW       = $clog2(LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output lane_t         pat_o,
  output logic          seq_end_o,
  output logic [IW-1:0] idx_o
);

  localparam logic [IW-1:0] LAST = IW'(LEN);

  logic [IW-1:0] idx_q;

  generate
    if ((FILLS % 2) == 0) begin : g_bad_fills
      $error("FILLS must be odd");
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q <= '0;
    end else if (idx_q != LAST) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign seq_end_o = (idx_q == LAST);
  assign pat_o     = pre_char(int'(idx_q), FILLS, FILL_BYTE);
  assign idx_o     = idx_q;

  // R7: a reset always returns the position to the first comma
  p_restart_r7: assert property (@(posedge clk_i) rst_i |=> idx_q == '0);

  // R5: once at the end the position never moves on its own
  p_hold_end_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_end_o |=> seq_end_o);

endmodule

// File: rtl/lnk_sync_out.sv
module lnk_sync_out
  import lnk_sync_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  logic  seq_end_i,
  input  lane_t pat_i,
  input  lane_t usr_i,
  output lane_t lane_o,
  output logic  done_o
);

  lane_t lane_q;
  logic  done_q;
  lane_t pick;

  assign pick = seq_end_i ? usr_i : pat_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lane_q <= '0;
      done_q <= 1'b0;
    end else begin
      lane_q <= pick;
      done_q <= seq_end_i;
    end
  end

  assign lane_o = lane_q;
  assign done_o = done_q;

  // R6: pass-through is exactly one register late
  p_pass_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    seq_end_i |=> (lane_o == $past(usr_i)));

  // R8: reset clears the lane and the done flag
  p_reset_clear_r8: assert property (@(posedge clk_i)
    rst_i |=> (lane_o == '0 && !done_o));

endmodule

// File: rtl/lnk_sync_gen.sv
module lnk_sync_gen
  import lnk_sync_pkg::*;
#(
  parameter int unsigned GROUPS    = 3,
  parameter int unsigned FILLS     = 1,
  parameter logic [7:0]  FILL_BYTE = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [7:0] usr_data_i,
  input  logic       usr_ctl_i,
  output logic [7:0] enc_data_o,
  output logic       enc_ctl_o,
  output logic       sync_done_o
);

  localparam int unsigned LEN = pre_len(GROUPS, FILLS);
  localparam int unsigned IW  = $clog2(LEN + 1);

  lane_t         pat_w;
  lane_t         usr_w;
  lane_t         lane_w;
  logic          seq_end_w;
  logic [IW-1:0] seq_idx_w;

  assign usr_w.ctl = usr_ctl_i;
  assign usr_w.dat = usr_data_i;

  lnk_sync_seq #(
    .GROUPS   (GROUPS),
    .FILLS    (FILLS),
    .FILL_BYTE(FILL_BYTE)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .pat_o    (pat_w),
    .seq_end_o(seq_end_w),
    .idx_o    (seq_idx_w)
  );

  lnk_sync_out u_out (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .seq_end_i(seq_end_w),
    .pat_i    (pat_w),
    .usr_i    (usr_w),
    .lane_o   (lane_w),
    .done_o   (sync_done_o)
  );

  assign enc_data_o = lane_w.dat;
  assign enc_ctl_o  = lane_w.ctl;

  // R1: first cycle after reset release shows the comma
  p_first_comma_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i) && !rst_i) |=> (enc_ctl_o && enc_data_o == COMMA_K285));

  // R2/R4: during the preamble a control char can only be the comma
  p_only_comma_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sync_done_o && enc_ctl_o) |-> enc_data_o == COMMA_K285);

  // R3: during the preamble every data char is the fill byte
  p_fill_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!sync_done_o && seq_idx_w != '0 && !enc_ctl_o) |-> enc_data_o == FILL_BYTE);

  // R5: done rises only right after a fill character
  p_done_after_fill_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sync_done_o) |-> !$past(enc_ctl_o));

endmodule

// File: tb/lnk_sync_gen_test.sv
module lnk_sync_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ud  = 8'h00;
  logic       uc  = 1'b0;
  logic [7:0] a_d, b_d;
  logic       a_c, b_c, a_done, b_done;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] prev_d;
  logic       prev_c;

  always #2.5 clk = ~clk;

  lnk_sync_gen uut (
    .clk_i(clk), .rst_i(rst), .usr_data_i(ud), .usr_ctl_i(uc),
    .enc_data_o(a_d), .enc_ctl_o(a_c), .sync_done_o(a_done)
  );

  lnk_sync_gen #(.GROUPS(3), .FILLS(3), .FILL_BYTE(8'h4A)) uut_b (
    .clk_i(clk), .rst_i(rst), .usr_data_i(ud), .usr_ctl_i(uc),
    .enc_data_o(b_d), .enc_ctl_o(b_c), .sync_done_o(b_done)
  );

  // {done, ctl, data} for the default instance over the preamble
  localparam int LEN_A = 6;
  localparam logic [9:0] EXP_A [LEN_A] = '{
    10'h1BC, 10'h000, 10'h1BC, 10'h000, 10'h1BC, 10'h000
  };
  localparam int LEN_B = 12;

  function automatic logic [9:0] exp_b(int i);
    if (i % 4 == 0) return {2'b01, 8'hBC};
    return {2'b00, 8'h4A};
  endfunction

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // release reset and walk both streams for ncyc cycles, user side feeding commas
  task automatic run_stream(int ncyc);
    @(negedge clk);
    rst = 1'b0;
    ud = 8'hBC; uc = 1'b1;
    prev_d = ud; prev_c = uc;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c < LEN_A) chk("R1 R2 R4 uut", {a_done, a_c, a_d}, EXP_A[c]);
      else           chk("R5 R6 uut", {a_done, a_c, a_d}, {1'b1, prev_c, prev_d});
      if (c < LEN_B) chk("R2 R3 R4 uut_b", {b_done, b_c, b_d}, exp_b(c));
      else           chk("R5 R6 uut_b", {b_done, b_c, b_d}, {1'b1, prev_c, prev_d});
      ud = (c < LEN_B) ? 8'hBC : 8'(c * 37 + 5);
      uc = (c < LEN_B) ? 1'b1 : c[0];
      prev_d = ud; prev_c = uc;
    end
  endtask

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 uut", {a_done, a_c, a_d}, 10'h000);
    chk("R8 uut_b", {b_done, b_c, b_d}, 10'h000);

    run_stream(20);

    // R5: done stays high with long idle traffic
    repeat (30) @(negedge clk);
    chk("R5 hold", {a_done, b_done}, 10'h3);

    // R7: reset part-way through the preamble
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 reset again", {a_done, a_c, a_d}, 10'h000);
    rst = 1'b0; ud = 8'hBC; uc = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 mid-seq uut", {a_done, a_c, a_d}, EXP_A[2]);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid-seq clear", {a_done, a_c, a_d}, 10'h000);
    run_stream(16);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule